// File: doc/BRIEF.md
# Supply Supervisor Reset and Shipping-Seal Sequencer

This block is the digital half of a supply supervisor. It receives a comparator flag that is high while the supply is above the reset threshold, an active-low push-button reset, and the sensed level of a status pin that a production fixture can hold low. It drives an active-low reset to the processor. The reset stays low while the supply is bad or the button is pressed. It then stays low for one full timeout after the last cause goes away.

The same timeout counter also sets when the status pin is sampled. If a production fixture holds the pin low at both the midpoint and the three-quarter point of the timeout, a shipping seal is armed. From then on the push button is ignored. On the next supply failure the battery-connect output drops, which keeps the backup cell disconnected during storage. The seal is cleared, and the battery reconnected, as soon as the supply returns above threshold.

All three inputs pass through two-flop synchronizers. An asynchronous power-on clear puts the block into a known state.

Top module: `por_seal_top`

## Requirements
- R1: While the supply flag is low, `resetN` is low; a falling supply flag driven before clock edge 1 forces `resetN` low at edge 3 (two synchronizer stages plus the state register).
- R2: A supply flag rising before edge 1 (with the push button released) leaves `resetN` low through edge 2+T and raises it at edge 3+T, where T is `TIMEOUT_CYCLES`.
- R3: A supply dip during the timeout clears the count; `resetN` rises T+3 edges after the supply returns, not counting any time accumulated before the dip.
- R4: Every low period of `resetN` lasts at least T cycles, including those caused by brownouts.
- R5: With no seal armed, a low on `manRstNIn` drives `resetN` low three edges later; `resetN` stays low while the button is held and rises T+3 edges after it is released.
- R6: The seal arms only when the synchronized status pin reads low both when the timeout count equals T/2 and when it equals 3T/4 (integer division). A pin that is high at either point leaves the battery connected through later supply failures.
- R7: Once the T/2 sample reads low, the push button is ignored for the rest of that timeout. While the seal is armed, the push button has no effect on `resetN`.
- R8: With the seal armed, a supply failure drives `battConnect` low three edges after the flag falls, on the same edge as `resetN` goes low.
- R9: A rising supply flag drives `battConnect` high again three edges later and clears the seal, so a following supply failure keeps the battery connected.
- R10: While `porN` is low, `resetN` is low and `battConnect` is high at once, without waiting for a clock edge; the seal is disarmed and the count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porN | input | 1 | Asynchronous power-on clear, active low |
| supplyOkIn | input | 1 | Comparator flag, high while supply is above the reset threshold (asynchronous) |
| manRstNIn | input | 1 | Push-button reset, active low (asynchronous) |
| statusPinIn | input | 1 | Sensed level of the fixture-controlled status pin (asynchronous) |
| resetN | output | 1 | Processor reset, active low |
| battConnect | output | 1 | High while the backup battery may be connected |

## Verification
An input change reaches the outputs three clock edges after it is driven: two synchronizer stages and the state register. A release of reset therefore shows up at edge T+3, and the timeout counts from the edge at which the synchronized cause goes away. The status-pin samples fall at edges T/2+4 and 3T/4+4 after the supply rises. The driver records the edge count at which each stimulus is applied and queues the expected `resetN` and `battConnect` values at both edge 2+T and edge 3+T, or at both edge 2 and edge 3 for immediate effects. The monitor compares each queued item at the falling clock edge of exactly that cycle, so a change that comes one cycle early or one cycle late is caught.

// File: rtl/por_seal_pkg.sv
package por_seal_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_TIMING = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic takeFirst;
    logic dropSamples;
  } seq_strobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic atHalf;
    logic atThreeQ;
    logic atLast;
    logic firstLow;
    logic secondHit;
  } seq_flags_t;

endpackage

// File: rtl/por_seal_sync.sv
module por_seal_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         porN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;

endmodule

// File: rtl/por_seal_datapath.sv
module por_seal_datapath
  import por_seal_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 20_000_000
) (
  input  logic        clk,
  input  logic        porN,
  input  seq_strobe_t strobe,
  input  logic        statusLvl,
  output seq_flags_t  flags
);

  localparam int CNT_W    = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HALF_PT  = TIMEOUT_CYCLES / 2;
  localparam int THREEQ   = (TIMEOUT_CYCLES / 4) * 3 + ((TIMEOUT_CYCLES % 4) * 3) / 4;
  localparam int LAST_PT  = TIMEOUT_CYCLES - 1;

  logic [CNT_W-1:0] cnt;
  logic             firstLow;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt <= '0;
    end else if (strobe.cntClear) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // first status sample: pin low at the midpoint
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      firstLow <= 1'b0;
    end else if (strobe.dropSamples) begin
      firstLow <= 1'b0;
    end else if (strobe.takeFirst) begin
      firstLow <= ~statusLvl;
    end
  end

  always_comb begin
    flags.atHalf    = (cnt == CNT_W'(HALF_PT));
    flags.atThreeQ  = (cnt == CNT_W'(THREEQ));
    flags.atLast    = (cnt == CNT_W'(LAST_PT));
    flags.firstLow  = firstLow;
    flags.secondHit = firstLow & ~statusLvl;
  end

endmodule

// File: rtl/por_seal_ctrl.sv
module por_seal_ctrl
  import por_seal_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        supOk,
  input  logic        mrN,
  input  seq_flags_t  flags,
  output seq_strobe_t strobe,
  output logic        resetN,
  output logic        battConnect,
  output logic        sealArmed
);

  seq_state_t state;
  seq_state_t nextState;
  logic       armed;
  logic       sealActive;
  logic       ignoreMr;
  logic       mrAct;
  logic       armNow;

  assign ignoreMr = flags.firstLow | armed;
  assign mrAct    = ~mrN & ~ignoreMr;

  always_comb begin
    nextState = state;
    strobe    = '0;
    armNow    = 1'b0;
    unique case (state)
      ST_HOLD: begin
        strobe.cntClear    = 1'b1;
        strobe.dropSamples = 1'b1;
        if (supOk && !mrAct) nextState = ST_TIMING;
      end
      ST_TIMING: begin
        if (!supOk || mrAct) begin
          nextState          = ST_HOLD;
          strobe.cntClear    = 1'b1;
          strobe.dropSamples = 1'b1;
        end else if (flags.atLast) begin
          nextState          = ST_RUN;
          strobe.cntClear    = 1'b1;
          strobe.dropSamples = 1'b1;
        end else begin
          strobe.cntInc    = 1'b1;
          strobe.takeFirst = flags.atHalf;
          armNow           = flags.atThreeQ & flags.secondHit;
        end
      end
      ST_RUN: begin
        strobe.cntClear    = 1'b1;
        strobe.dropSamples = 1'b1;
        if (!supOk || mrAct) nextState = ST_HOLD;
      end
      default: begin
        nextState       = ST_HOLD;
        strobe.cntClear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_HOLD;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      armed      <= 1'b0;
      sealActive <= 1'b0;
    end else if (sealActive) begin
      if (supOk) sealActive <= 1'b0;
    end else if (armed && !supOk) begin
      sealActive <= 1'b1;
      armed      <= 1'b0;
    end else if (armNow) begin
      armed <= 1'b1;
    end
  end

  assign resetN      = (state == ST_RUN);
  assign battConnect = ~sealActive;
  assign sealArmed   = armed;

endmodule

// File: rtl/por_seal_top.sv
module por_seal_top
  import por_seal_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 20_000_000
) (
  input  logic clk,
  input  logic porN,
  input  logic supplyOkIn,
  input  logic manRstNIn,
  input  logic statusPinIn,
  output logic resetN,
  output logic battConnect
);

  initial begin
    if (TIMEOUT_CYCLES < 8) $error("TIMEOUT_CYCLES must be at least 8");
  end

  logic [2:0]  syncOut;
  logic        supOkS;
  logic        mrS;
  logic        statusS;
  logic        sealArmed;
  seq_strobe_t strobe;
  seq_flags_t  flags;

  por_seal_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .porN (porN),
    .din  ({manRstNIn, statusPinIn, supplyOkIn}),
    .dout (syncOut)
  );

  assign supOkS  = syncOut[0];
  assign statusS = syncOut[1];
  assign mrS     = syncOut[2];

  por_seal_datapath #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .strobe    (strobe),
    .statusLvl (statusS),
    .flags     (flags)
  );

  por_seal_ctrl u_ctrl (
    .clk         (clk),
    .porN        (porN),
    .supOk       (supOkS),
    .mrN         (mrS),
    .flags       (flags),
    .strobe      (strobe),
    .resetN      (resetN),
    .battConnect (battConnect),
    .sealArmed   (sealArmed)
  );

endmodule

// File: rtl/por_seal_checker.sv
module por_seal_checker #(
  parameter int TIMEOUT_CYCLES = 20_000_000
) (
  input logic clk,
  input logic porN,
  input logic supOkS,
  input logic mrS,
  input logic statusS,
  input logic sealArmed,
  input logic resetN,
  input logic battConnect
);

  localparam int LW = $clog2(TIMEOUT_CYCLES + 1);

  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                             lowCnt <= '0;
    else if (resetN)                       lowCnt <= '0;
    else if (lowCnt != LW'(TIMEOUT_CYCLES)) lowCnt <= lowCnt + LW'(1);
  end

  // R1: bad supply forces reset on the next edge
  p_low_on_bad_supply_r1: assert property (@(posedge clk) disable iff (!porN)
    !supOkS |=> !resetN);

  // R4: every reset pulse is at least one timeout long
  p_min_pulse_r4: assert property (@(posedge clk) disable iff (!porN)
    $rose(resetN) |-> (lowCnt >= LW'(TIMEOUT_CYCLES)));

  // R5: button asserts reset from run when no seal is armed
  p_button_asserts_r5: assert property (@(posedge clk) disable iff (!porN)
    (resetN && !mrS && !sealArmed) |=> !resetN);

  // R6: arming only follows a low status sample
  p_arm_needs_low_r6: assert property (@(posedge clk) disable iff (!porN)
    $rose(sealArmed) |-> !$past(statusS));

  // R8: armed seal plus supply failure drops battery
  p_batt_off_r8: assert property (@(posedge clk) disable iff (!porN)
    (sealArmed && !supOkS) |=> !battConnect);

  // R9: returning supply reconnects battery
  p_batt_back_r9: assert property (@(posedge clk) disable iff (!porN)
    (!battConnect && supOkS) |=> battConnect);

endmodule

bind por_seal_top por_seal_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk         (clk),
  .porN        (porN),
  .supOkS      (supOkS),
  .mrS         (mrS),
  .statusS     (statusS),
  .sealArmed   (sealArmed),
  .resetN      (resetN),
  .battConnect (battConnect)
);

// File: tb/por_seal_top_test.sv
module por_seal_top_test;

  localparam int T = 40;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyOkIn = 1'b0;
  logic manRstNIn = 1'b1;
  logic statusPinIn = 1'b1;
  logic resetN;
  logic battConnect;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    logic  rn;
    logic  bc;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t it;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  por_seal_top #(.TIMEOUT_CYCLES(T)) uut (
    .clk         (clk),
    .porN        (porN),
    .supplyOkIn  (supplyOkIn),
    .manRstNIn   (manRstNIn),
    .statusPinIn (statusPinIn),
    .resetN      (resetN),
    .battConnect (battConnect)
  );

  // driver side: queue an expectation, kept sorted by cycle
  task automatic expectAt(int off, logic rn, logic bc, string tag);
    exp_t e;
    int   pos;
    e.at = cyc + off; e.rn = rn; e.bc = bc; e.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > e.at) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  task automatic direct(string tag, logic rn, logic bc);
    checks++;
    if (resetN !== rn || battConnect !== bc) begin
      failures++;
      $display("FAIL %s: resetN=%b battConnect=%b expected resetN=%b battConnect=%b",
               tag, resetN, battConnect, rn, bc);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued items in their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      it = q.pop_front();
      checks++;
      if (it.at != cyc || resetN !== it.rn || battConnect !== it.bc) begin
        failures++;
        $display("FAIL %s @%0d: resetN=%b battConnect=%b expected resetN=%b battConnect=%b",
                 it.tag, it.at, resetN, battConnect, it.rn, it.bc);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish();
  end

  initial begin
    // R10: reset state under the power-on clear
    waitCyc(3);
    direct("R10 clear state", 1'b0, 1'b1);
    porN = 1'b1;
    waitCyc(3);
    direct("R1 supply low after clear", 1'b0, 1'b1);

    // R2: power up
    supplyOkIn = 1'b1;
    expectAt(3, 1'b0, 1'b1, "R2 still low early");
    expectAt(2 + T, 1'b0, 1'b1, "R2 low at T+2");
    expectAt(3 + T, 1'b1, 1'b1, "R2 high at T+3");
    waitCyc(T + 10);

    // R1 + R4: brownout, then a full timeout
    supplyOkIn = 1'b0;
    expectAt(2, 1'b1, 1'b1, "R1 before latency");
    expectAt(3, 1'b0, 1'b1, "R1 brownout");
    waitCyc(5);
    supplyOkIn = 1'b1;
    expectAt(2 + T, 1'b0, 1'b1, "R4 brownout pulse T+2");
    expectAt(3 + T, 1'b1, 1'b1, "R4 brownout pulse end");
    waitCyc(T + 10);

    // R3: dip during the timeout restarts the count
    supplyOkIn = 1'b0;
    waitCyc(6);
    supplyOkIn = 1'b1;
    waitCyc(20);
    supplyOkIn = 1'b0;
    waitCyc(3);
    supplyOkIn = 1'b1;
    expectAt(2 + T, 1'b0, 1'b1, "R3 restart T+2");
    expectAt(3 + T, 1'b1, 1'b1, "R3 restart end");
    waitCyc(T + 10);

    // R5: push button in run
    manRstNIn = 1'b0;
    expectAt(3, 1'b0, 1'b1, "R5 button asserts");
    waitCyc(12);
    direct("R5 held low", 1'b0, 1'b1);
    manRstNIn = 1'b1;
    expectAt(2 + T, 1'b0, 1'b1, "R5 release T+2");
    expectAt(3 + T, 1'b1, 1'b1, "R5 release end");
    waitCyc(T + 10);

    // R6 + R7 + R8 + R9: arm the seal
    supplyOkIn = 1'b0;
    statusPinIn = 1'b0;
    waitCyc(6);
    supplyOkIn = 1'b1;
    expectAt(38, 1'b0, 1'b1, "R7 button ignored in timeout");
    expectAt(3 + T, 1'b1, 1'b1, "R7 timeout not restarted");
    waitCyc(28);
    manRstNIn = 1'b0;
    waitCyc(5);
    manRstNIn = 1'b1;
    waitCyc(T);
    manRstNIn = 1'b0;
    expectAt(3, 1'b1, 1'b1, "R7 button ignored while armed");
    expectAt(6, 1'b1, 1'b1, "R7 button ignored while armed");
    waitCyc(6);
    manRstNIn = 1'b1;
    waitCyc(6);
    supplyOkIn = 1'b0;
    expectAt(2, 1'b1, 1'b1, "R8 before latency");
    expectAt(3, 1'b0, 1'b0, "R8 battery off");
    waitCyc(5);
    statusPinIn = 1'b1;
    waitCyc(5);
    supplyOkIn = 1'b1;
    expectAt(2, 1'b0, 1'b0, "R9 still off");
    expectAt(3, 1'b0, 1'b1, "R9 battery back");
    expectAt(3 + T, 1'b1, 1'b1, "R9 run after seal");
    waitCyc(T + 10);
    supplyOkIn = 1'b0;
    expectAt(3, 1'b0, 1'b1, "R9 seal cleared");
    expectAt(8, 1'b0, 1'b1, "R9 seal cleared");
    waitCyc(10);

    // R6: only the midpoint sample low -> no seal
    statusPinIn = 1'b0;
    supplyOkIn = 1'b1;
    expectAt(3 + T, 1'b1, 1'b1, "R6 run reached");
    waitCyc(26);
    statusPinIn = 1'b1;
    waitCyc(T);
    supplyOkIn = 1'b0;
    expectAt(3, 1'b0, 1'b1, "R6 not armed");
    expectAt(6, 1'b0, 1'b1, "R6 not armed");
    waitCyc(8);
    supplyOkIn = 1'b1;
    waitCyc(T + 10);
    manRstNIn = 1'b0;
    expectAt(3, 1'b0, 1'b1, "R6 button live after one sample");
    waitCyc(6);
    manRstNIn = 1'b1;
    waitCyc(T + 10);
    direct("R5 run after release", 1'b1, 1'b1);

    // R10: asynchronous clear in run
    @(posedge clk);
    #2;
    porN = 1'b0;
    #1;
    direct("R10 async clear", 1'b0, 1'b1);
    waitCyc(3);
    porN = 1'b1;
    waitCyc(T + 10);
    direct("R10 run after clear", 1'b1, 1'b1);

    waitCyc(4);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    finish();
  end

endmodule